// File: doc/BRIEF.md
# Pixel to Bit-Plane Transposer

This block turns a stream of pixels into bit-plane words. On each accepted pixel it takes one 8-bit intensity per colour channel (red, green, blue). After it has collected a group of consecutive pixels, it rotates that group so that each output word gathers the same bit weight from every pixel of the group. Each word therefore describes one weight level rather than one pixel. A downstream memory can then store each word in the slice reserved for its weight.

The three channels use identical, independent datapaths and share one group counter and one emission sequencer. A collection stage fills while the previous group is still being emitted, so at the default sizes a continuous pixel stream never waits. When a group completes before the emission of the previous group is nearly done, which happens when the group is shorter than the sample width, the input is held back with a ready flag. Reset is synchronous and discards any partly collected group.

Top module: `bitplane_transposer`

## Requirements
- R1: In the cycle after a synchronous reset, `plane_valid` is 0 and `pix_ready` is 1.
- R2: A pixel counts toward a group only when `pix_valid` and `pix_ready` are both high at a clock edge. Idle cycles inside a group do not change the group's content or the order of its pixels.
- R3: In the word for weight k, bit i equals bit k of the i-th pixel of the group. Pixel 0 is the first one accepted and sits in the LSB.
- R4: The group's words appear on consecutive cycles with `plane_weight` counting 0, 1, … SAMPLE_W-1. Weight 0 is presented in the cycle right after the clock edge that accepted the group's last pixel.
- R5: Each colour channel's words are built only from that channel's own input bytes.
- R6: Collection is double-buffered. When the group size equals the sample width, a gap-free pixel stream is never stalled (`pix_ready` stays 1).
- R7: `pix_ready` is 0 exactly when the next pixel would complete a group while the current emission still has two or more words left, counting the one on the outputs now. A pixel offered while `pix_ready` is 0 is not taken.
- R8: A reset in the middle of a group discards the pixels already collected. The next GROUP_N accepted pixels form a fresh group.
- R9: `plane_valid` is high for exactly SAMPLE_W cycles per group, one per word, and falls after the last weight unless a new group starts in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel bytes are present this cycle |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| red_in | input | SAMPLE_W | Red intensity |
| green_in | input | SAMPLE_W | Green intensity |
| blue_in | input | SAMPLE_W | Blue intensity |
| plane_valid | output | 1 | A bit-plane word is on the outputs |
| plane_weight | output | clog2(SAMPLE_W) | Bit weight of the present words |
| plane_red | output | GROUP_N | Red bit-plane word |
| plane_green | output | GROUP_N | Green bit-plane word |
| plane_blue | output | GROUP_N | Blue bit-plane word |

## Verification
The assertions check the following on every cycle:
- the group counter stays in range, wraps on the carry and holds during idle cycles;
- the weight steps by one and starts at zero after each carry;
- emission goes idle after the last weight;
- no carry can arrive while two or more words are still pending.

Some behaviours need the bench's scenarios and reference model:
- the bit rotation itself, which covers the full byte range, walking ones and gapped input;
- channel independence;
- the absence of stalls at the default size;
- the stall pattern of a shorter group;
- the discarding of a partial group across a reset.

// File: rtl/bitplane_pkg.sv
package bitplane_pkg;
  localparam int SAMPLE_W_DEF = 8;
  localparam int GROUP_N_DEF  = 8;
  localparam int NUM_CH       = 3;

  typedef enum logic [1:0] {CH_RED = 2'd0, CH_GREEN = 2'd1, CH_BLUE = 2'd2} chan_e;

  // index width for a count of n items (at least one bit)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bp_group_counter.sv
module bp_group_counter #(
  parameter int GROUP_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic [bitplane_pkg::idx_bits(GROUP_N)-1:0] slot,
  output logic group_done
);
  localparam int CW = bitplane_pkg::idx_bits(GROUP_N);
  localparam logic [CW-1:0] LAST_SLOT = CW'(GROUP_N - 1);

  logic [CW-1:0] slot_q;

  assign slot       = slot_q;
  assign group_done = accept && (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst)         slot_q <= '0;
    else if (accept) slot_q <= group_done ? '0 : slot_q + 1'b1;
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST_SLOT); // R2
  AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (rst)
    group_done |=> slot_q == '0); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(slot_q)); // R2
endmodule

// File: rtl/bp_collect.sv
module bp_collect #(
  parameter int SAMPLE_W = 8,
  parameter int GROUP_N  = 8
) (
  input  logic clk,
  input  logic wr_en,
  input  logic [bitplane_pkg::idx_bits(GROUP_N)-1:0] wr_slot,
  input  logic [SAMPLE_W-1:0] din,
  output logic [GROUP_N-1:0][SAMPLE_W-1:0] grp
);
  localparam int CW = bitplane_pkg::idx_bits(GROUP_N);

  // slots 0..GROUP_N-2 are registered; the final pixel passes straight
  // through so the whole group is ready on the carry edge
  for (genvar s = 0; s < GROUP_N - 1; s++) begin : g_slot
    logic [SAMPLE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == CW'(s))) q <= din;
    end
    assign grp[s] = q;
  end
  assign grp[GROUP_N-1] = din;
endmodule

// File: rtl/bp_serializer.sv
module bp_serializer #(
  parameter int SAMPLE_W = 8,
  parameter int GROUP_N  = 8
) (
  input  logic clk,
  input  logic load,
  input  logic [GROUP_N-1:0][SAMPLE_W-1:0] grp_in,
  input  logic [bitplane_pkg::idx_bits(SAMPLE_W)-1:0] weight,
  output logic [GROUP_N-1:0] word
);
  localparam int WW = bitplane_pkg::idx_bits(SAMPLE_W);

  logic [GROUP_N-1:0][SAMPLE_W-1:0] hold_q;

  // gather bit k of every pixel, pixel i landing in bit i
  function automatic logic [GROUP_N-1:0] plane_of(
    input logic [GROUP_N-1:0][SAMPLE_W-1:0] g,
    input logic [WW-1:0] k
  );
    logic [GROUP_N-1:0] w;
    for (int i = 0; i < GROUP_N; i++) w[i] = g[i][k];
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (load) hold_q <= grp_in;
  end

  assign word = plane_of(hold_q, weight);
endmodule

// File: rtl/bp_emit_ctrl.sv
module bp_emit_ctrl #(
  parameter int SAMPLE_W = 8,
  parameter int GROUP_N  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic group_done,
  input  logic [bitplane_pkg::idx_bits(GROUP_N)-1:0] slot,
  output logic busy,
  output logic last_word,
  output logic [bitplane_pkg::idx_bits(SAMPLE_W)-1:0] weight,
  output logic ready
);
  localparam int CW = bitplane_pkg::idx_bits(GROUP_N);
  localparam int WW = bitplane_pkg::idx_bits(SAMPLE_W);
  localparam logic [CW-1:0] LAST_SLOT = CW'(GROUP_N - 1);
  localparam logic [WW-1:0] LAST_WT   = WW'(SAMPLE_W - 1);

  logic          busy_q;
  logic [WW-1:0] wt_q;

  assign busy      = busy_q;
  assign weight    = wt_q;
  assign last_word = busy_q && (wt_q == LAST_WT);
  // hold back a group-completing pixel until the hold register frees up
  assign ready     = (slot != LAST_SLOT) || !busy_q || last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wt_q   <= '0;
    end else if (group_done) begin
      busy_q <= 1'b1;
      wt_q   <= '0;
    end else if (busy_q) begin
      if (wt_q == LAST_WT) begin
        busy_q <= 1'b0;
        wt_q   <= '0;
      end else begin
        wt_q <= wt_q + 1'b1;
      end
    end
  end

  AST_WEIGHT_STEP: assert property (@(posedge clk) disable iff (rst)
    busy_q && !last_word |=> busy_q && (wt_q == $past(wt_q) + 1'b1)); // R4
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    group_done |=> busy_q && (wt_q == '0)); // R4
  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    last_word && !group_done |=> !busy_q); // R9
endmodule

// File: rtl/bitplane_transposer.sv
module bitplane_transposer #(
  parameter int SAMPLE_W = bitplane_pkg::SAMPLE_W_DEF,
  parameter int GROUP_N  = bitplane_pkg::GROUP_N_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pix_valid,
  output logic                        pix_ready,
  input  logic [SAMPLE_W-1:0]         red_in,
  input  logic [SAMPLE_W-1:0]         green_in,
  input  logic [SAMPLE_W-1:0]         blue_in,
  output logic                        plane_valid,
  output logic [$clog2(SAMPLE_W)-1:0] plane_weight,
  output logic [GROUP_N-1:0]          plane_red,
  output logic [GROUP_N-1:0]          plane_green,
  output logic [GROUP_N-1:0]          plane_blue
);
  import bitplane_pkg::*;

  localparam int CW = idx_bits(GROUP_N);
  localparam int WW = idx_bits(SAMPLE_W);

  logic          accept;
  logic          group_done;
  logic [CW-1:0] slot;
  logic          busy;
  logic          last_word;
  logic [WW-1:0] weight;

  logic [SAMPLE_W-1:0] ch_in   [NUM_CH];
  logic [GROUP_N-1:0]  ch_word [NUM_CH];

  assign accept = pix_valid && pix_ready;

  assign ch_in[CH_RED]   = red_in;
  assign ch_in[CH_GREEN] = green_in;
  assign ch_in[CH_BLUE]  = blue_in;

  bp_group_counter #(.GROUP_N(GROUP_N)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .slot       (slot),
    .group_done (group_done)
  );

  bp_emit_ctrl #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .group_done (group_done),
    .slot       (slot),
    .busy       (busy),
    .last_word  (last_word),
    .weight     (weight),
    .ready      (pix_ready)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [GROUP_N-1:0][SAMPLE_W-1:0] grp;

    bp_collect #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N)) u_collect (
      .clk     (clk),
      .wr_en   (accept),
      .wr_slot (slot),
      .din     (ch_in[c]),
      .grp     (grp)
    );

    bp_serializer #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N)) u_ser (
      .clk    (clk),
      .load   (group_done),
      .grp_in (grp),
      .weight (weight),
      .word   (ch_word[c])
    );
  end

  assign plane_valid  = busy;
  assign plane_weight = weight;
  assign plane_red    = ch_word[CH_RED];
  assign plane_green  = ch_word[CH_GREEN];
  assign plane_blue   = ch_word[CH_BLUE];

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    group_done |-> (!busy || last_word)); // R7
  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !pix_ready |-> busy && !last_word); // R7
endmodule

// File: tb/test_bitplane_transposer.sv
module bench_lane #(
  parameter int G = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_valid,
  input  logic [7:0] r_in,
  input  logic [7:0] g_in,
  input  logic [7:0] b_in,
  input  int         phase,
  output int         checks,
  output int         fails,
  output int         stalls
);
  logic         ready, vld;
  logic [2:0]   wt;
  logic [G-1:0] pr, pg, pb;

  bitplane_transposer #(.SAMPLE_W(8), .GROUP_N(G)) i_bitplane_transposer (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(ready),
    .red_in(r_in), .green_in(g_in), .blue_in(b_in),
    .plane_valid(vld), .plane_weight(wt),
    .plane_red(pr), .plane_green(pg), .plane_blue(pb)
  );

  int pix   [3][G];
  int words [3][8];
  int cnt = 0, rem = 0;
  bit seen = 0, was_rst = 0, exp_rdy = 1;

  initial begin checks = 0; fails = 0; stalls = 0; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (G=%0d) actual=%0d expected=%0d at %0t", tag, G, act, exp, $time);
    end
  endtask

  function automatic string word_tag();
    return (phase == 2) ? "R2" : (phase == 8) ? "R8" : "R3";
  endfunction

  always @(negedge clk) begin
    #1;
    if (seen) begin
      if (was_rst) begin
        chk(vld == 1'b0,  "R1", int'(vld), 0);
        chk(ready == 1'b1, "R1", int'(ready), 1);
      end
      chk(vld == (rem > 0), "R9", int'(vld), int'(rem > 0));
      if (vld && rem > 0) begin
        chk(int'(wt) == 8 - rem, "R4", int'(wt), 8 - rem);
        chk(int'(pr) == words[0][8-rem], word_tag(), int'(pr), words[0][8-rem]);
        chk(int'(pg) == words[1][8-rem], "R5", int'(pg), words[1][8-rem]);
        chk(int'(pb) == words[2][8-rem], "R5", int'(pb), words[2][8-rem]);
      end
      exp_rdy = !(cnt == G - 1 && rem >= 2);
      chk(ready == exp_rdy, "R7", int'(ready), int'(exp_rdy));
      if (!ready) stalls++;
    end
    if (rst) begin
      seen = 1; was_rst = 1; cnt = 0; rem = 0; exp_rdy = 1;
    end else begin
      was_rst = 0;
      if (seen) begin
        if (rem > 0) rem--;
        if (pix_valid && exp_rdy) begin
          pix[0][cnt] = r_in; pix[1][cnt] = g_in; pix[2][cnt] = b_in;
          cnt++;
          if (cnt == G) begin
            for (int c = 0; c < 3; c++)
              for (int k = 0; k < 8; k++) begin
                words[c][k] = 0;
                for (int i = 0; i < G; i++)
                  words[c][k] += ((pix[c][i] >> k) & 1) * (1 << i);
              end
            rem = 8;
            cnt = 0;
          end
        end
      end
    end
  end
endmodule

module test_bitplane_transposer;
  logic clk = 0;
  logic rst = 1;
  logic pix_valid = 0;
  logic [7:0] r_in = 0, g_in = 0, b_in = 0;
  int phase = 3;
  int ca, fa, sa, cb, fb, sb;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bench_lane #(.G(8)) u_lane_full (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .r_in(r_in), .g_in(g_in),
    .b_in(b_in), .phase(phase), .checks(ca), .fails(fa), .stalls(sa));
  bench_lane #(.G(4)) u_lane_short (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .r_in(r_in), .g_in(g_in),
    .b_in(b_in), .phase(phase), .checks(cb), .fails(fb), .stalls(sb));

  task automatic drive(input bit v, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    @(negedge clk);
    pix_valid = v; r_in = r; g_in = g; b_in = b;
  endtask

  task automatic own_chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    checks += ca + cb;
    fails  += fa + fb;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) drive(0, 0, 0, 0);
    rst = 0;                                   // R1 checked by the lanes
    // walking ones: transposes to a diagonal (R3)
    for (int i = 0; i < 8; i++) drive(1, 8'(1 << i), 8'(8'h80 >> i), 8'hFF);
    // full byte sweep, gap-free (R3, R5, R6)
    for (int v = 0; v < 256; v++) drive(1, 8'(v), 8'(v) ^ 8'hA5, 8'((v * 29 + 7) & 255));
    // gapped input (R2)
    phase = 2;
    for (int i = 0; i < 96; i++) drive(i % 3 != 1, 8'(i * 13), 8'(255 - i), 8'(i * 7 + 3));
    // partial group then reset (R8)
    phase = 8;
    for (int i = 0; i < 5; i++) drive(1, 8'hEE, 8'hEE, 8'hEE);
    rst = 1;
    drive(1, 8'h11, 8'h22, 8'h33);
    rst = 0;
    for (int i = 0; i < 24; i++) drive(1, 8'(i * 11 + 1), 8'(i ^ 8'h3C), 8'(i * 5));
    repeat (30) drive(0, 0, 0, 0);
    @(negedge clk); #2;
    own_chk(sa == 0, "R6", sa, 0);             // equal sizes never stall
    own_chk(sb > 0, "R7", sb, 1);              // short group must stall
    finished = 1;
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule